// File: doc/BRIEF.md
# Write Precompensation Delay Selector

This block shifts individual pulses of a serial write-data stream by a programmable number of reference-clock ticks, so that pulses crowded by their neighbours reach the medium early or late by a controlled amount. The clock is a 24 MHz reference, so one tick is about 41.7 ns. A 3-bit precompensation code selects the shift. A 2-bit rate code and an MFM/FM select identify the data rate. Together they choose the default shift and flag the one combination that is not allowed.

Each incoming pulse carries a tag from the upstream pattern look-ahead: nominal, early or late. All pulses pass through a common base latency equal to the selected shift. Early pulses skip that base latency and late pulses take it twice, so both move by exactly the selected amount relative to nominal pulses. Precompensation is active only on tracks at or beyond a programmed threshold track. On inner tracks, and whenever the rate is illegal, no pulse is moved relative to the others.

Top module: `wpc_precomp`

## Requirements
- R1: Codes 001 through 110 on `pc_code` set `delay_ticks` to 1 through 6 respectively, for any legal rate.
- R2: Code 111 on `pc_code` sets `delay_ticks` to 0.
- R3: Code 000 selects the default shift. In MFM mode (`mfm_sel`=1) with rate code 11 (1 Mbps) it is 1 tick. At every other legal rate (MFM codes 00/01/10, meaning 500/300/250 kbps, and FM codes 00/01/10, meaning 250/150/125 kbps) it is 3 ticks.
- R4: FM mode (`mfm_sel`=0) with rate code 11 raises `rate_illegal` and forces `delay_ticks` to 0, so every pulse takes zero shift.
- R5: A pulse sampled on `wr_pulse` at clock edge t appears on `wr_pulse_out` for exactly one cycle, starting right after edge t+A, where A is the applied shift in ticks.
- R6: On tracks at or above the threshold, A is `delay_ticks` for tag 00 (nominal), 0 for tag 01 (early), and twice `delay_ticks` for tag 10 (late). Tag 11 is treated as nominal.
- R7: When `track_now` is below `pc_track`, A equals `delay_ticks` for every tag. When `track_now` equals `pc_track`, the tagged shift of R6 applies.
- R8: While reset is asserted, and right after it is released, `wr_pulse_out` is 0, and pulses presented during reset never appear.
- R9: `rate_illegal` is 0 for every MFM rate code and for FM rate codes 00, 01 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz reference clock; one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_code | input | 3 | Precompensation shift code |
| rate_code | input | 2 | Data rate code |
| mfm_sel | input | 1 | 1 = MFM encoding, 0 = FM |
| track_now | input | TRACK_W (8) | Track currently being written |
| pc_track | input | TRACK_W (8) | First track on which precompensation applies |
| wr_pulse | input | 1 | Write-data pulse, one cycle wide |
| pulse_tag | input | 2 | Tag of the current pulse: 00 nominal, 01 early, 10 late, 11 nominal |
| wr_pulse_out | output | 1 | Shifted write-data pulse |
| delay_ticks | output | SEL_W (3) | Selected shift in ticks after rate masking |
| rate_illegal | output | 1 | FM at the fastest rate code |

## Verification
A wrong decode entry shows up at once on `delay_ticks`. It also shows up as a pulse arriving at the wrong cycle, because every pulse's base latency depends on the decoded shift. A fault in tag handling or in the track comparison appears only on the delayed output, 0 to 12 cycles after the pulse enters. The bench therefore measures the exact arrival cycle and the width of every pulse. A stuck or leaking delay line appears as a missing pulse, an extra pulse or a widened pulse within one window of 13 cycles.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  typedef enum logic [1:0] {
    TAG_NOM   = 2'b00,
    TAG_EARLY = 2'b01,
    TAG_LATE  = 2'b10,
    TAG_ALT   = 2'b11
  } pc_tag_e;

  // Shift selected by a code; fast_rate picks the short default for code 000.
  function automatic logic [2:0] code_to_ticks(input logic [2:0] code,
                                               input logic fast_rate);
    logic [2:0] t;
    case (code)
      3'b000:  t = fast_rate ? 3'd1 : 3'd3;
      3'b111:  t = 3'd0;
      default: t = code;
    endcase
    return t;
  endfunction

  // Shift applied to one pulse, given the base shift and its tag.
  function automatic logic [3:0] tagged_shift(input logic [2:0] base,
                                              input pc_tag_e tag,
                                              input logic active);
    logic [3:0] b;
    logic [3:0] r;
    b = {1'b0, base};
    if (!active)               r = b;
    else if (tag == TAG_EARLY) r = 4'd0;
    else if (tag == TAG_LATE)  r = b << 1;
    else                       r = b;
    return r;
  endfunction

endpackage

// File: rtl/wpc_rate_decode.sv
module wpc_rate_decode #(
  parameter int SEL_W = 3
) (
  input  logic [2:0]       code,
  input  logic [1:0]       rate,
  input  logic             mfm,
  output logic [SEL_W-1:0] sel,
  output logic             illegal
);
  import wpc_pkg::*;

  logic       fast_rate;
  logic [2:0] raw_ticks;

  assign illegal   = !mfm && (rate == 2'b11);
  assign fast_rate = mfm && (rate == 2'b11);
  assign raw_ticks = code_to_ticks(code, fast_rate);
  assign sel       = illegal ? '0 : SEL_W'(raw_ticks);

endmodule

// File: rtl/wpc_tag_shift.sv
module wpc_tag_shift #(
  parameter int SEL_W = 3,
  parameter int APP_W = SEL_W + 1
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       tag,
  input  logic             active,
  output logic [APP_W-1:0] applied
);
  import wpc_pkg::*;

  pc_tag_e    tag_e;
  logic [3:0] shift_raw;

  assign tag_e     = pc_tag_e'(tag);
  assign shift_raw = tagged_shift(3'(sel), tag_e, active);
  assign applied   = APP_W'(shift_raw);

endmodule

// File: rtl/wpc_pulse_line.sv
module wpc_pulse_line #(
  parameter int DEPTH = 13,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins,
  input  logic [IDX_W-1:0] ins_pos,
  output logic             pulse_out
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [DEPTH-1:0] line_q;
  logic [DEPTH-1:0] line_d;
  logic             ins_ok;

  assign ins_ok = ins && (ins_pos <= LAST);

  always_comb begin
    line_d = {1'b0, line_q[DEPTH-1:1]};
    if (ins_ok) line_d[ins_pos] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  assign pulse_out = line_q[0];

  // R5
  zero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins && ins_pos == '0) |=> pulse_out);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins && line_q[DEPTH-1:1] == '0) |=> !pulse_out);

endmodule

// File: rtl/wpc_precomp.sv
module wpc_precomp #(
  parameter int TRACK_W = 8,
  parameter int SEL_W   = 3,
  parameter int MAX_SEL = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         pc_code,
  input  logic [1:0]         rate_code,
  input  logic               mfm_sel,
  input  logic [TRACK_W-1:0] track_now,
  input  logic [TRACK_W-1:0] pc_track,
  input  logic               wr_pulse,
  input  logic [1:0]         pulse_tag,
  output logic               wr_pulse_out,
  output logic [SEL_W-1:0]   delay_ticks,
  output logic               rate_illegal
);
  import wpc_pkg::*;

  localparam int APP_W = SEL_W + 1;
  localparam int DEPTH = 2 * MAX_SEL + 1;
  localparam int IDX_W = $clog2(DEPTH);

  logic [SEL_W-1:0] sel_ticks;
  logic             illegal_w;
  logic             zone_active;
  logic [APP_W-1:0] applied_w;

  assign zone_active = (track_now >= pc_track) && !illegal_w;

  wpc_rate_decode #(.SEL_W(SEL_W)) dec_i (
    .code    (pc_code),
    .rate    (rate_code),
    .mfm     (mfm_sel),
    .sel     (sel_ticks),
    .illegal (illegal_w)
  );

  wpc_tag_shift #(.SEL_W(SEL_W), .APP_W(APP_W)) tag_i (
    .sel     (sel_ticks),
    .tag     (pulse_tag),
    .active  (zone_active),
    .applied (applied_w)
  );

  wpc_pulse_line #(.DEPTH(DEPTH), .IDX_W(IDX_W)) line_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins       (wr_pulse),
    .ins_pos   (IDX_W'(applied_w)),
    .pulse_out (wr_pulse_out)
  );

  assign delay_ticks  = sel_ticks;
  assign rate_illegal = illegal_w;

  // R1
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, delay_ticks} <= (SEL_W+1)'(MAX_SEL));

  // R4
  illegal_unshifted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_illegal |-> (applied_w == '0));

  // R7
  inner_track_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (track_now < pc_track) |-> (applied_w == {1'b0, delay_ticks}));

  // R6
  late_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (track_now >= pc_track && pulse_tag == 2'b10)
      |-> (applied_w == ({1'b0, delay_ticks} << 1)));

endmodule

// File: tb/wpc_precomp_tb.sv
module wpc_precomp_tb_top;
  localparam int CLK_PERIOD = 42;
  localparam int WINDOW     = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pc_code = '0;
  logic [1:0] rate_code = '0;
  logic       mfm_sel = 1'b1;
  logic [7:0] track_now = '0;
  logic [7:0] pc_track = 8'd40;
  logic       wr_pulse = 1'b0;
  logic [1:0] pulse_tag = '0;
  logic       wr_pulse_out;
  logic [2:0] delay_ticks;
  logic       rate_illegal;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wpc_precomp dut_i (
    .clk(clk), .rst_n(rst_n), .pc_code(pc_code), .rate_code(rate_code),
    .mfm_sel(mfm_sel), .track_now(track_now), .pc_track(pc_track),
    .wr_pulse(wr_pulse), .pulse_tag(pulse_tag), .wr_pulse_out(wr_pulse_out),
    .delay_ticks(delay_ticks), .rate_illegal(rate_illegal)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (code=%0d rate=%0d mfm=%0d trk=%0d tag=%0d)",
               req, act, exp, pc_code, rate_code, mfm_sel, track_now, pulse_tag);
    end
  endtask

  function automatic int exp_ticks(int code, int rate, int mfm);
    if (mfm == 0 && rate == 3) return 0;
    if (code >= 1 && code <= 6) return code;
    if (code == 7) return 0;
    return (mfm == 1 && rate == 3) ? 1 : 3;
  endfunction

  function automatic int exp_shift(int d, int tag, int below);
    if (below != 0) return d;
    case (tag)
      1: return 0;
      2: return d + d;
      default: return d;
    endcase
  endfunction

  // Sends one pulse and returns the cycle index of its arrival and the count of high samples.
  task automatic send_pulse(output int first, output int highs);
    first = -1;
    highs = 0;
    @(negedge clk);
    wr_pulse = 1'b1;
    for (int k = 0; k < WINDOW; k++) begin
      @(negedge clk);
      wr_pulse = 1'b0;
      if (wr_pulse_out) begin
        highs++;
        if (first < 0) first = k;
      end
    end
  endtask

  initial begin
    int first;
    int highs;
    // R8: pulses offered during reset never appear
    wr_pulse = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 out during reset", int'(wr_pulse_out), 0);
    wr_pulse = 1'b0;
    rst_n = 1'b1;
    for (int k = 0; k < WINDOW; k++) begin
      @(negedge clk);
      check("R8 out after reset", int'(wr_pulse_out), 0);
    end

    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 8; c++)
          for (int z = 0; z < 3; z++)
            for (int t = 0; t < 4; t++) begin
              int d;
              int sh;
              mfm_sel   = m[0];
              rate_code = r[1:0];
              pc_code   = c[2:0];
              track_now = 8'(39 + z);
              pulse_tag = t[1:0];
              #1;
              d = exp_ticks(c, r, m);
              if (c >= 1 && c <= 6) check("R1 delay_ticks", int'(delay_ticks), d);
              else if (c == 7)      check("R2 delay_ticks", int'(delay_ticks), d);
              else                  check("R3 delay_ticks", int'(delay_ticks), d);
              if (m == 0 && r == 3) check("R4 rate_illegal", int'(rate_illegal), 1);
              else                  check("R9 rate_illegal", int'(rate_illegal), 0);
              sh = exp_shift(d, t, (z == 0) ? 1 : 0);
              send_pulse(first, highs);
              if (m == 0 && r == 3) check("R4 arrival", first, 0);
              else if (z == 0)      check("R7 arrival below", first, sh);
              else if (z == 1)      check("R7 arrival at threshold", first, sh);
              else                  check("R6 arrival", first, sh);
              check("R5 pulse width", highs, 1);
            end

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule